// File: doc/BRIEF.md
# Parallel Leaf Rule Matcher

The block takes one packet header (source and destination address, source and destination port, protocol) and tests it against every rule slot of one wide rule-memory word in the same cycle. A leaf of a classification tree is given as a start slot and a rule count. Only slots inside that window take part. Among the slots that match, the lowest-numbered one wins. Its 16-bit rule number is returned one cycle later. The rule order inside the leaf is therefore its priority order.

A leaf may run past the last slot of a word. If no enabled slot matches and rules are still left, the block raises a request for the next word. It then carries on from slot 0 of that word with the remaining count, using the header it captured at the start. When the count runs out without a hit, the block reports a miss. A search that starts at slot 0 and ends at leaf position z therefore takes floor(z/NSLOT)+1 word cycles.

The controller has two states. IDLE accepts a new search on `go`, using the word present in that cycle. FETCH waits for `word_valid` with the next word. There are four transitions:
- IDLE to IDLE: a hit, or the last word of the leaf, or no `go`.
- IDLE to FETCH: a miss with rules remaining.
- FETCH to FETCH: a further miss with rules remaining.
- FETCH to IDLE: a hit or the end of the leaf.

Top module: `leaf_matcher`

## Requirements
- R1: Each 160-bit slot i occupies word bits [160*i+159 : 160*i]. The fields of a slot are, from MSB to LSB:
  - disable flag (1 bit; when set, the slot never matches)
  - source port max (16), source port min (16)
  - destination port max (16), destination port min (16)
  - source prefix code (3), source address (32)
  - destination prefix code (3), destination address (32)
  - protocol wildcard (1), protocol value (8)
  - rule number (16)
- R2: A port field matches when min <= header port <= max, both bounds inclusive.
- R3: The protocol matches when its wildcard bit is 1, or when the header protocol equals the stored 8-bit value.
- R4: Address prefix codes work as follows:
  - Prefix code values 0 to 3 give prefix lengths 32, 31, 30 and 29 against the full stored address.
  - Code values 4 to 7 give prefix length {code[1:0], addr[2:0]}, and address bits [2:0] are never compared.
  - Bits below the prefix are ignored. Code 4 with address bits [2:0] = 0 is a full wildcard.
- R5: In the first word, only slots with start <= i < start+count take part. In each following word, only slots with i < remaining count take part.
- R6: When several enabled slots match, the lowest slot index wins.
- R7: A search is evaluated in the cycle `go` (IDLE) or `word_valid` (FETCH) is high. `res_valid` pulses for one cycle on the next cycle. For a hit, `res_hit`=1 and `res_rule` carries the rule number.
- R8: If no enabled slot matches and count > NSLOT-start (or remaining > NSLOT in FETCH), `next_word_req` rises on the next cycle. It stays high until a cycle with `word_valid`, and no result is given meanwhile. The search then resumes at slot 0 with count reduced by the slots already covered.
- R9: When the leaf ends without a hit, a result is given with `res_valid`=1, `res_hit`=0 and `res_rule`=16'hFFFF. A count of 0 gives this miss on the next cycle.
- R10: While `next_word_req` is high, `go`, `start_slot`, `rule_count` and the header inputs have no effect. The header captured with `go` is used for every word of the search.
- R11: After reset, `res_valid`=0, `res_hit`=0, `res_rule`=16'hFFFF, `next_word_req`=0, and the block is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start a leaf search with the current word (IDLE only) |
| start_slot | input | $clog2(NSLOT) | First slot of the leaf in the current word |
| rule_count | input | CW | Number of rules in the leaf |
| hdr_sip | input | 32 | Header source address |
| hdr_dip | input | 32 | Header destination address |
| hdr_sport | input | 16 | Header source port |
| hdr_dport | input | 16 | Header destination port |
| hdr_proto | input | 8 | Header protocol |
| word_valid | input | 1 | Next rule word present (FETCH only) |
| word_data | input | NSLOT*160 | Rule memory word |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | A rule matched |
| res_rule | output | 16 | Matching rule number, or 16'hFFFF on a miss |
| next_word_req | output | 1 | Request for the following rule word |

## Verification
A wrong controller state shows within one cycle of the evaluation, in one of three ways:
- a FETCH entered by mistake raises `next_word_req` with no result;
- a missed spill gives a premature miss;
- a stray IDLE during a spill lets a new `go` produce a result while a request is pending.

A wrong remaining count or a stale captured header appears only after the next `word_valid`. It shows as a wrong rule number, or as a hit or miss on the wrong slot. Comparator faults (bounds, prefix decode, protocol wildcard, disable flag) appear as a wrong `res_hit` or `res_rule` in the cycle after `go`.

// File: rtl/lm_pkg.sv
package lm_pkg;

    localparam int RULE_W = 160;

    typedef struct packed {
        logic [15:0] sp_hi;
        logic [15:0] sp_lo;
        logic [15:0] dp_hi;
        logic [15:0] dp_lo;
        logic [2:0]  s_code;
        logic [31:0] s_addr;
        logic [2:0]  d_code;
        logic [31:0] d_addr;
        logic        p_any;
        logic [7:0]  p_val;
    } lm_key_t;

    typedef struct packed {
        logic        off;
        lm_key_t     key;
        logic [15:0] rnum;
    } lm_rule_t;

    typedef struct packed {
        logic [31:0] sip;
        logic [31:0] dip;
        logic [15:0] sport;
        logic [15:0] dport;
        logic [7:0]  proto;
    } lm_hdr_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } lm_state_t;

    // Prefix mask from the 3-bit code and the three low address bits.
    function automatic logic [31:0] lm_prefix_mask(input logic [2:0] code,
                                                   input logic [2:0] low);
        logic [5:0]  plen;
        logic [31:0] m;
        if (code[2]) plen = {1'b0, code[1:0], low};
        else         plen = 6'd32 - {3'b000, code};
        m = ~(32'hFFFF_FFFF >> plen);
        if (code[2]) m[2:0] = 3'b000;
        return m;
    endfunction

endpackage

// File: rtl/lm_slot_cmp.sv
module lm_slot_cmp
    import lm_pkg::*;
(
    input  logic    off,
    input  lm_key_t key,
    input  lm_hdr_t hdr,
    output logic    hit
);
    logic [31:0] s_mask;
    logic [31:0] d_mask;
    logic        sp_ok;
    logic        dp_ok;
    logic        s_ok;
    logic        d_ok;
    logic        p_ok;

    always_comb begin
        s_mask = lm_prefix_mask(key.s_code, key.s_addr[2:0]);
        d_mask = lm_prefix_mask(key.d_code, key.d_addr[2:0]);
        sp_ok  = (hdr.sport >= key.sp_lo) && (hdr.sport <= key.sp_hi);
        dp_ok  = (hdr.dport >= key.dp_lo) && (hdr.dport <= key.dp_hi);
        s_ok   = ((hdr.sip ^ key.s_addr) & s_mask) == 32'd0;
        d_ok   = ((hdr.dip ^ key.d_addr) & d_mask) == 32'd0;
        p_ok   = key.p_any || (hdr.proto == key.p_val);
        hit    = !off && sp_ok && dp_ok && s_ok && d_ok && p_ok;
    end
endmodule

// File: rtl/lm_window.sv
module lm_window #(
    parameter int NSLOT = 30,
    parameter int CW    = 16,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic [SW-1:0] base,
    input  logic [CW-1:0] cnt,
    output logic [NSLOT-1:0] en,
    output logic          last,
    output logic [CW-1:0] left
);
    logic [31:0] tail;

    always_comb begin
        tail = (32'(base) >= 32'(NSLOT)) ? 32'd0 : 32'(NSLOT) - 32'(base);
        for (int i = 0; i < NSLOT; i++) begin
            en[i] = (32'(i) >= 32'(base)) && (32'(i) < 32'(base) + 32'(cnt));
        end
        last = 32'(cnt) <= tail;
        left = last ? '0 : CW'(32'(cnt) - tail);
    end
endmodule

// File: rtl/lm_first.sv
module lm_first #(
    parameter int NSLOT = 30
) (
    input  logic [NSLOT-1:0] req,
    output logic             any,
    output logic [NSLOT-1:0] grant
);
    logic seen;

    always_comb begin
        seen  = 1'b0;
        grant = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (req[i] && !seen) begin
                grant[i] = 1'b1;
                seen     = 1'b1;
            end
        end
        any = seen;
    end
endmodule

// File: rtl/leaf_matcher.sv
module leaf_matcher
    import lm_pkg::*;
#(
    parameter int NSLOT = 30,
    parameter int CW    = 16,
    localparam int SW   = $clog2(NSLOT),
    localparam int WORD_W = NSLOT * RULE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [SW-1:0]     start_slot,
    input  logic [CW-1:0]     rule_count,
    input  logic [31:0]       hdr_sip,
    input  logic [31:0]       hdr_dip,
    input  logic [15:0]       hdr_sport,
    input  logic [15:0]       hdr_dport,
    input  logic [7:0]        hdr_proto,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              res_valid,
    output logic              res_hit,
    output logic [15:0]       res_rule,
    output logic              next_word_req
);
    lm_state_t   state_q, state_d;
    logic [CW-1:0] remain_q, remain_d;
    lm_hdr_t     hdr_q, hdr_in, cur_hdr;

    logic [SW-1:0]    cur_base;
    logic [CW-1:0]    cur_cnt;
    logic             eval;
    logic [NSLOT-1:0] en;
    logic             last;
    logic [CW-1:0]    left;
    logic [NSLOT-1:0] slot_hit;
    logic [NSLOT-1:0] grant;
    logic             any;
    logic [15:0]      slot_num [NSLOT];
    logic [15:0]      win_num;

    logic             fire;
    logic             fire_hit;
    logic [15:0]      fire_rule;

    assign hdr_in = '{sip: hdr_sip, dip: hdr_dip, sport: hdr_sport,
                      dport: hdr_dport, proto: hdr_proto};

    always_comb begin
        if (state_q == ST_IDLE) begin
            cur_base = start_slot;
            cur_cnt  = rule_count;
            cur_hdr  = hdr_in;
            eval     = go;
        end else begin
            cur_base = '0;
            cur_cnt  = remain_q;
            cur_hdr  = hdr_q;
            eval     = word_valid;
        end
    end

    lm_window #(.NSLOT(NSLOT), .CW(CW)) u_win (
        .base (cur_base),
        .cnt  (cur_cnt),
        .en   (en),
        .last (last),
        .left (left)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        lm_rule_t rule;
        logic     raw_hit;
        assign rule = word_data[g*RULE_W +: RULE_W];
        lm_slot_cmp u_cmp (
            .off (rule.off),
            .key (rule.key),
            .hdr (cur_hdr),
            .hit (raw_hit)
        );
        assign slot_hit[g] = raw_hit && en[g];
        assign slot_num[g] = rule.rnum;
    end

    lm_first #(.NSLOT(NSLOT)) u_first (
        .req   (slot_hit),
        .any   (any),
        .grant (grant)
    );

    always_comb begin
        win_num = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (grant[i]) win_num = win_num | slot_num[i];
        end
    end

    // Next-state and result decision.
    always_comb begin
        state_d   = state_q;
        remain_d  = remain_q;
        fire      = 1'b0;
        fire_hit  = 1'b0;
        fire_rule = 16'hFFFF;
        unique case (state_q)
            ST_IDLE, ST_FETCH: begin
                if (eval) begin
                    if (any) begin
                        fire      = 1'b1;
                        fire_hit  = 1'b1;
                        fire_rule = win_num;
                        state_d   = ST_IDLE;
                    end else if (last) begin
                        fire      = 1'b1;
                        state_d   = ST_IDLE;
                    end else begin
                        remain_d  = left;
                        state_d   = ST_FETCH;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            hdr_q    <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
            if (state_q == ST_IDLE && go) hdr_q <= hdr_in;
        end
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_rule  <= 16'hFFFF;
        end else begin
            res_valid <= fire;
            res_hit   <= fire && fire_hit;
            if (fire) res_rule <= fire_rule;
        end
    end

    assign next_word_req = (state_q == ST_FETCH);

endmodule

// File: rtl/lm_chk.sv
module lm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        word_valid,
    input logic        res_valid,
    input logic        res_hit,
    input logic [15:0] res_rule,
    input logic        next_word_req
);
    // R7
    hit_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);

    // R9
    miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_rule == 16'hFFFF));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (next_word_req && !word_valid) |=> next_word_req);

    // R8
    req_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !next_word_req);

    // R10
    fetch_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (next_word_req && !word_valid) |=> !res_valid);
endmodule

bind leaf_matcher lm_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_valid    (word_valid),
    .res_valid     (res_valid),
    .res_hit       (res_hit),
    .res_rule      (res_rule),
    .next_word_req (next_word_req)
);

// File: tb/leaf_matcher_test.sv
module leaf_matcher_test;
    localparam int NSLOT = 30;
    localparam int CW = 16;
    localparam int WW = NSLOT * 160;

    typedef struct packed {
        logic [31:0] sip;
        logic [31:0] dip;
        logic [15:0] sp;
        logic [15:0] dp;
        logic [7:0]  pr;
        logic [4:0]  st;
        logic [15:0] cnt;
        logic        hit;
        logic [15:0] rn;
    } vec_t;

    localparam int NV = 19;
    // R2 R3 R4 R5 R6 R1 vectors against word A
    localparam vec_t VECS [NV] = '{
        '{32'h0A010203, 32'h01020304, 16'd1500, 16'd443, 8'd6,  5'd0,  16'd4, 1'b1, 16'd100},
        '{32'h0A010203, 32'h01020304, 16'd1500, 16'd443, 8'd17, 5'd0,  16'd4, 1'b1, 16'd103},
        '{32'h0A010203, 32'h01020304, 16'd1500, 16'd443, 8'd6,  5'd1,  16'd3, 1'b1, 16'd103},
        '{32'h0A010203, 32'h01020304, 16'd1000, 16'd443, 8'd6,  5'd0,  16'd1, 1'b1, 16'd100},
        '{32'h0A010203, 32'h01020304, 16'd2000, 16'd443, 8'd6,  5'd0,  16'd1, 1'b1, 16'd100},
        '{32'h0A010203, 32'h01020304, 16'd2001, 16'd443, 8'd6,  5'd0,  16'd1, 1'b0, 16'hFFFF},
        '{32'h0A010203, 32'h01020304, 16'd999,  16'd443, 8'd6,  5'd0,  16'd1, 1'b0, 16'hFFFF},
        '{32'hC0A80101, 32'h01020304, 16'd1,    16'd2,   8'd50, 5'd1,  16'd1, 1'b1, 16'd101},
        '{32'hC0A80102, 32'h01020304, 16'd1,    16'd2,   8'd50, 5'd1,  16'd1, 1'b0, 16'hFFFF},
        '{32'h01010101, 32'hC0A8FF01, 16'd9,    16'd80,  8'd17, 5'd2,  16'd1, 1'b1, 16'd102},
        '{32'h01010101, 32'hC0A90001, 16'd9,    16'd80,  8'd17, 5'd2,  16'd1, 1'b0, 16'hFFFF},
        '{32'h01010101, 32'hC0A8FF01, 16'd9,    16'd81,  8'd17, 5'd2,  16'd1, 1'b0, 16'hFFFF},
        '{32'h01010101, 32'hC0A8FF01, 16'd9,    16'd80,  8'd6,  5'd2,  16'd1, 1'b0, 16'hFFFF},
        '{32'h0B000007, 32'h01020304, 16'd1,    16'd1,   8'd1,  5'd20, 16'd1, 1'b1, 16'd120},
        '{32'h0B000008, 32'h01020304, 16'd1,    16'd1,   8'd1,  5'd20, 16'd1, 1'b0, 16'hFFFF},
        '{32'h0B000003, 32'h01020304, 16'd1,    16'd1,   8'd1,  5'd20, 16'd1, 1'b0, 16'hFFFF},
        '{32'h0AFFFFFF, 32'h01020304, 16'd1500, 16'd1,   8'd6,  5'd0,  16'd1, 1'b1, 16'd100},
        '{32'h0B010203, 32'h01020304, 16'd1500, 16'd1,   8'd6,  5'd0,  16'd1, 1'b0, 16'hFFFF},
        '{32'h01020304, 32'h01020304, 16'd1,    16'd1,   8'd1,  5'd4,  16'd1, 1'b0, 16'hFFFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [4:0] start_slot = '0;
    logic [CW-1:0] rule_count = '0;
    logic [31:0] hdr_sip = '0, hdr_dip = '0;
    logic [15:0] hdr_sport = '0, hdr_dport = '0;
    logic [7:0] hdr_proto = '0;
    logic word_valid = 1'b0;
    logic [WW-1:0] word_data = '0;
    logic res_valid, res_hit, next_word_req;
    logic [15:0] res_rule;

    logic [WW-1:0] word_a, word_b, word_c;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    leaf_matcher #(.NSLOT(NSLOT), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .start_slot(start_slot),
        .rule_count(rule_count), .hdr_sip(hdr_sip), .hdr_dip(hdr_dip),
        .hdr_sport(hdr_sport), .hdr_dport(hdr_dport), .hdr_proto(hdr_proto),
        .word_valid(word_valid), .word_data(word_data), .res_valid(res_valid),
        .res_hit(res_hit), .res_rule(res_rule), .next_word_req(next_word_req)
    );

    // R1 layout: off, sp_hi, sp_lo, dp_hi, dp_lo, s_code, s_addr, d_code, d_addr, p_any, p_val, rnum
    function automatic logic [159:0] mk(input logic off,
        input logic [15:0] sl, input logic [15:0] sh,
        input logic [15:0] dl, input logic [15:0] dh,
        input logic [2:0] sc, input logic [31:0] sa,
        input logic [2:0] dc, input logic [31:0] da,
        input logic pa, input logic [7:0] pv, input logic [15:0] rn);
        return {off, sh, sl, dh, dl, sc, sa, dc, da, pa, pv, rn};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic launch(input logic [31:0] sip, input logic [15:0] sp,
                          input logic [4:0] st, input logic [15:0] cnt);
        @(negedge clk);
        hdr_sip = sip; hdr_dip = 32'h01020304; hdr_sport = sp;
        hdr_dport = 16'd1; hdr_proto = 8'd1;
        start_slot = st; rule_count = cnt; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic feed(input logic [WW-1:0] w);
        word_data = w; word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        word_a = '0;
        word_a[0*160 +: 160] = mk(1'b0, 16'd1000, 16'd2000, 16'd0, 16'hFFFF,
                                  3'd5, 32'h0A000000, 3'd4, 32'h0, 1'b0, 8'd6, 16'd100);
        word_a[1*160 +: 160] = mk(1'b0, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF,
                                  3'd0, 32'hC0A80101, 3'd4, 32'h0, 1'b1, 8'd0, 16'd101);
        word_a[2*160 +: 160] = mk(1'b0, 16'd0, 16'hFFFF, 16'd80, 16'd80,
                                  3'd4, 32'h0, 3'd6, 32'hC0A80000, 1'b0, 8'd17, 16'd102);
        word_a[3*160 +: 160] = mk(1'b0, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF,
                                  3'd4, 32'h0, 3'd4, 32'h0, 1'b1, 8'd0, 16'd103);
        word_a[4*160 +: 160] = mk(1'b1, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF,
                                  3'd4, 32'h0, 3'd4, 32'h0, 1'b1, 8'd0, 16'd104);
        word_a[20*160 +: 160] = mk(1'b0, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF,
                                   3'd2, 32'h0B000004, 3'd4, 32'h0, 1'b1, 8'd0, 16'd120);
        word_a[29*160 +: 160] = mk(1'b0, 16'd5, 16'd5, 16'd0, 16'hFFFF,
                                   3'd4, 32'h0, 3'd4, 32'h0, 1'b1, 8'd0, 16'd129);
        word_b = '0;
        word_b[2*160 +: 160] = mk(1'b0, 16'd7, 16'd7, 16'd0, 16'hFFFF,
                                  3'd4, 32'h0, 3'd4, 32'h0, 1'b1, 8'd0, 16'd202);
        word_c = '0;
        word_data = word_a;

        // R11 reset state
        repeat (3) @(negedge clk);
        check("R11 reset outputs", {13'd0, res_valid, res_hit, res_rule, next_word_req},
              {13'd0, 1'b0, 1'b0, 16'hFFFF, 1'b0});
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R7 R1
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            hdr_sip = VECS[k].sip; hdr_dip = VECS[k].dip; hdr_sport = VECS[k].sp;
            hdr_dport = VECS[k].dp; hdr_proto = VECS[k].pr;
            start_slot = VECS[k].st; rule_count = VECS[k].cnt; go = 1'b1;
            @(negedge clk);
            go = 1'b0;
            check($sformatf("R1/R2/R3/R4/R5/R6/R7 vector %0d", k),
                  {13'd0, res_valid, res_hit, res_rule, next_word_req},
                  {13'd0, 1'b1, VECS[k].hit, VECS[k].rn, 1'b0});
            @(negedge clk);
            check("R7 single pulse", {31'd0, res_valid}, 32'd0);
        end

        // R9 count zero gives immediate miss
        launch(32'h01020304, 16'd1, 5'd0, 16'd0);
        check("R9 zero count", {13'd0, res_valid, res_hit, res_rule, next_word_req},
              {13'd0, 1'b1, 1'b0, 16'hFFFF, 1'b0});

        // R9 leaf ending exactly at last slot: miss, no request
        launch(32'h01020304, 16'd7, 5'd28, 16'd2);
        check("R9 end of word miss", {13'd0, res_valid, res_hit, res_rule, next_word_req},
              {13'd0, 1'b1, 1'b0, 16'hFFFF, 1'b0});

        // R6 hit in first word of a spilling leaf: no request
        launch(32'h01020304, 16'd5, 5'd28, 16'd5);
        check("R6 hit before spill", {13'd0, res_valid, res_hit, res_rule, next_word_req},
              {13'd0, 1'b1, 1'b1, 16'd129, 1'b0});

        // R8 R10 spill to word B, header captured, go ignored during FETCH
        launch(32'h01020304, 16'd7, 5'd28, 16'd5);
        check("R8 request raised", {30'd0, res_valid, next_word_req}, 32'd1);
        go = 1'b1; start_slot = 5'd3; rule_count = 16'd1; hdr_sport = 16'd9;
        @(negedge clk);
        go = 1'b0;
        check("R10 go ignored in fetch", {30'd0, res_valid, next_word_req}, 32'd1);
        feed(word_b);
        check("R8 R10 resume with captured header",
              {13'd0, res_valid, res_hit, res_rule, next_word_req},
              {13'd0, 1'b1, 1'b1, 16'd202, 1'b0});
        word_data = word_a;

        // R8 spill over two words ending in miss
        launch(32'h01020304, 16'd7, 5'd29, 16'd33);
        check("R8 request after first word", {30'd0, res_valid, next_word_req}, 32'd1);
        feed(word_c);
        check("R8 request kept with rules left", {30'd0, res_valid, next_word_req}, 32'd1);
        feed(word_b);
        check("R8 R9 remaining count ends leaf",
              {13'd0, res_valid, res_hit, res_rule, next_word_req},
              {13'd0, 1'b1, 1'b0, 16'hFFFF, 1'b0});
        word_data = word_a;

        // R5 remaining count limits slots in the following word
        launch(32'h01020304, 16'd7, 5'd28, 16'd4);
        feed(word_b);
        check("R5 remaining window excludes slot 2",
              {13'd0, res_valid, res_hit, res_rule, next_word_req},
              {13'd0, 1'b1, 1'b0, 16'hFFFF, 1'b0});
        word_data = word_a;

        // R11 reset during FETCH
        launch(32'h01020304, 16'd7, 5'd28, 16'd5);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset clears request", {13'd0, res_valid, res_hit, res_rule, next_word_req},
              {13'd0, 1'b0, 1'b0, 16'hFFFF, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule